// File: doc/BRIEF.md
# Escaping UART Byte Transmitter

This block turns a stream of bytes into an asynchronous serial line: one start bit (low), eight data bits with the least significant bit first, and one stop bit (high), at a fixed bit period. The line idles high. Bytes arrive on a valid/ready handshake and leave on a single `tx` wire.

Control-range bytes are made printable on the wire. Any byte below 0x21 goes out as two characters: first the marker 0x20, then the original value with bit 7 forced to one. Every other byte goes out unchanged. A receiver reverses the expansion. When it sees 0x20, it clears bit 7 of the next character. A bare 0x20 is never sent as data, so the marker cannot be mistaken for a data byte.

The bit period is a parameter given in clock cycles. The default of 1664 cycles (16 × 104) gives 9600 baud from a 16 MHz clock. Reset is synchronous and active high.

Top module: `esc_uart_tx`

## Requirements
- R1: After reset, `tx` is high and `in_ready` is high.
- R2: A byte of value 0x21 or above, accepted when `in_valid` and `in_ready` are both high at a rising edge, goes out as one frame. The start bit begins in the cycle after acceptance. The frame is start bit 0, data bits 0 to 7 in that order, then stop bit 1. Each bit lasts exactly CLKS_PER_BIT cycles.
- R3: A byte below 0x21 goes out as two frames: first the character 0x20, then the byte OR 0x80.
- R4: Between the two frames of an escape pair, the line stays high for exactly one cycle after the first stop bit, and then the second start bit begins.
- R5: `in_ready` is high exactly when no frame is in progress and no second escape character is pending. After one accepted byte, it is low for 10×CLKS_PER_BIT cycles in the plain case and 20×CLKS_PER_BIT+1 cycles in the escaped case.
- R6: A byte presented while `in_ready` is low is not taken. `tx` and the bytes sent afterwards are unaffected by it.
- R7: Reset asserted in the middle of a frame ends it: the next cycle shows `tx` high and `in_ready` high.
- R8: All 256 byte values, sent back to back, are recovered in order by decoding the line and reversing the escape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| tx | output | 1 | Serial line, idles high |

## Verification
Errors in the internal state show up at the ports within a bit period, and often within one cycle. A bit counter or baud count that is off moves an edge of `tx` away from the expected cycle at the next bit boundary. A sequencer stuck in, or skipping, its held-character state either raises `in_ready` while the second character is still owed, or keeps it low after the line falls idle. Either fault shows in the cycle where the reference and the design first differ. A wrong escape threshold or flag value changes the data bits of the very next frame, and the line decoder catches it as a corrupted round trip.

// File: rtl/esc_tx_pkg.sv
package esc_tx_pkg;

    localparam logic [7:0] ESC_LIMIT  = 8'h21;
    localparam logic [7:0] ESC_MARK   = 8'h20;
    localparam logic [7:0] ESC_FLAG   = 8'h80;
    localparam int         FRAME_BITS = 10;
    localparam int         DATA_BITS  = 8;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_HOLD = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic                 load;
        logic [DATA_BITS-1:0] data;
    } char_req_t;

    function automatic logic needs_escape(input logic [7:0] b);
        return b < ESC_LIMIT;
    endfunction

    function automatic logic [7:0] escaped_form(input logic [7:0] b);
        return b | ESC_FLAG;
    endfunction

endpackage

// File: rtl/esc_baud_gen.sv
module esc_baud_gen #(
    parameter int CLKS_PER_BIT = 1664
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int CNT_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    // R2: the count never exceeds one bit period
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/esc_serializer.sv
module esc_serializer
    import esc_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  char_req_t req,
    input  logic      tick,
    output logic      busy,
    output logic      tx
);
    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [BIT_W-1:0]      bitcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '1;
            bitcnt <= '0;
            busy   <= 1'b0;
        end else if (req.load) begin
            shreg  <= {1'b1, req.data, 1'b0};
            bitcnt <= '0;
            busy   <= 1'b1;
        end else if (busy && tick) begin
            shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
            if (bitcnt == LAST_BIT) begin
                busy   <= 1'b0;
                bitcnt <= '0;
            end else begin
                bitcnt <= bitcnt + 1'b1;
            end
        end
    end

    assign tx = shreg[0];

    // R5: a new character is never loaded while a frame is in flight
    a_r5_no_load_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req.load);

    // R1: an idle line is high
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    // R2: the last bit period ends the frame with the line high
    a_r2_frame_ends: assert property (@(posedge clk) disable iff (rst)
        (busy && tick && bitcnt == LAST_BIT) |=> (!busy && tx));

    // R2: the bit counter stays inside one frame
    a_r2_bitcnt_range: assert property (@(posedge clk) disable iff (rst)
        bitcnt <= LAST_BIT);

endmodule

// File: rtl/esc_seq.sv
module esc_seq
    import esc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       ser_busy,
    output logic       in_ready,
    output char_req_t  req
);
    seq_state_t state;
    logic [7:0] held;
    logic       accept;

    assign in_ready = (state == SEQ_IDLE) && !ser_busy;
    assign accept   = in_valid && in_ready;

    always_comb begin
        req.load = 1'b0;
        req.data = held;
        if (accept) begin
            req.load = 1'b1;
            req.data = needs_escape(in_data) ? ESC_MARK : in_data;
        end else if (state == SEQ_HOLD && !ser_busy) begin
            req.load = 1'b1;
            req.data = held;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            held  <= '0;
        end else if (accept && needs_escape(in_data)) begin
            state <= SEQ_HOLD;
            held  <= escaped_form(in_data);
        end else if (state == SEQ_HOLD && !ser_busy) begin
            state <= SEQ_IDLE;
        end
    end

    // R5: no input byte is taken while the second escape character is owed
    a_r5_ready_low_in_hold: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_HOLD) |-> !in_ready);

    // R3: the held character always carries the top-bit flag
    a_r3_held_flagged: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_HOLD) |-> held[7]);

    // R6: a load only follows an accepted byte or a pending escape character
    a_r6_load_has_cause: assert property (@(posedge clk) disable iff (rst)
        req.load |-> ((in_valid && in_ready) || state == SEQ_HOLD));

endmodule

// File: rtl/esc_uart_tx.sv
module esc_uart_tx
    import esc_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16 * 104
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       tx
);
    char_req_t req;
    logic      busy;
    logic      tick;

    esc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .ser_busy (busy),
        .in_ready (in_ready),
        .req      (req)
    );

    esc_baud_gen #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_baud (
        .clk   (clk),
        .rst   (rst),
        .run   (busy),
        .clear (req.load),
        .tick  (tick)
    );

    esc_serializer u_ser (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .tick (tick),
        .busy (busy),
        .tx   (tx)
    );

    // R2: a frame begins with a low start bit in the cycle after a load
    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        req.load |=> !tx);

endmodule

// File: tb/esc_uart_tx_tb.sv
module esc_uart_tx_tb;

    localparam int C = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       tx;

    always #10 clk = ~clk;

    esc_uart_tx #(.CLKS_PER_BIT(C)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .tx       (tx)
    );

    int compared   = 0;
    int mismatched = 0;
    bit exp_q[$];
    logic [7:0] sent_q[$];
    bit rdy_s     = 1'b0;
    bit acc_flag  = 1'b0;
    bit checks_on = 1'b0;
    bit dec_on    = 1'b0;
    bit done      = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void push_frame(input logic [7:0] b);
        for (int i = 0; i < C; i++) exp_q.push_back(1'b0);
        for (int j = 0; j < 8; j++)
            for (int i = 0; i < C; i++) exp_q.push_back(b[j]);
        for (int i = 0; i < C; i++) exp_q.push_back(1'b1);
    endfunction

    // behavioural reference: expected line level per cycle
    always @(posedge clk) begin
        acc_flag = 1'b0;
        if (rst) begin
            exp_q.delete();
        end else begin
            if (exp_q.size() > 0) void'(exp_q.pop_front());
            if (in_valid && rdy_s) begin
                acc_flag = 1'b1;
                sent_q.push_back(in_data);
                if (in_data < 8'h21) begin
                    push_frame(8'h20);
                    exp_q.push_back(1'b1);
                    push_frame(in_data | 8'h80);
                end else begin
                    push_frame(in_data);
                end
            end
        end
    end

    // per-cycle comparison (R2 R3 R4 framing, R5 ready, R6 nothing stray)
    always @(negedge clk) begin
        rdy_s = in_ready;
        if (checks_on) begin
            chk(tx === ((exp_q.size() > 0) ? exp_q[0] : 1'b1), "R2 R3 R4 R6 line",
                int'(tx), int'((exp_q.size() > 0) ? exp_q[0] : 1'b1));
            chk(in_ready === (exp_q.size() == 0), "R5 ready",
                int'(in_ready), int'(exp_q.size() == 0));
        end
    end

    // line decoder with escape reversal (R3, R8)
    initial begin
        logic [7:0] rb;
        logic [7:0] expb;
        bit pend;
        pend = 1'b0;
        forever begin
            @(negedge clk);
            if (dec_on && !rst && tx == 1'b0) begin
                repeat (C / 2) @(negedge clk);
                chk(tx == 1'b0, "R2 start", int'(tx), 0);
                for (int j = 0; j < 8; j++) begin
                    repeat (C) @(negedge clk);
                    rb[j] = tx;
                end
                repeat (C) @(negedge clk);
                chk(tx == 1'b1, "R2 stop", int'(tx), 1);
                if (pend) begin
                    pend = 1'b0;
                    chk(rb[7] == 1'b1, "R3 flag", int'(rb), int'(rb | 8'h80));
                    expb = (sent_q.size() > 0) ? sent_q.pop_front() : 8'hxx;
                    chk((rb & 8'h7f) == expb && expb < 8'h21, "R8 escaped",
                        int'(rb & 8'h7f), int'(expb));
                end else if (rb == 8'h20) begin
                    pend = 1'b1;
                end else begin
                    expb = (sent_q.size() > 0) ? sent_q.pop_front() : 8'hxx;
                    chk(rb == expb && expb >= 8'h21, "R8 plain", int'(rb), int'(expb));
                end
            end
        end
    end

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        do @(negedge clk); while (!acc_flag);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!(in_ready && exp_q.size() == 0)) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tx == 1'b1, "R1 tx", int'(tx), 1);
        chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
        checks_on = 1'b1;
        dec_on    = 1'b1;
        rst       = 1'b0;
        @(negedge clk);

        // R8: every value back to back
        for (int v = 0; v < 256; v++) send(v[7:0]);
        wait_idle();

        // R2 R3: boundary values with gaps
        send(8'h20); repeat (5) @(negedge clk);
        send(8'h21); repeat (5) @(negedge clk);
        send(8'h00); repeat (3) @(negedge clk);
        send(8'h80); repeat (3) @(negedge clk);
        send(8'hff); repeat (3) @(negedge clk);
        wait_idle();

        // R5: busy windows for plain and escaped bytes
        begin
            int low;
            send(8'h41);
            low = 0;
            while (!in_ready) begin low++; @(negedge clk); end
            chk(low == 10 * C, "R5 plain window", low, 10 * C);
            send(8'h10);
            low = 0;
            while (!in_ready) begin low++; @(negedge clk); end
            chk(low == 20 * C + 1, "R5 escaped window", low, 20 * C + 1);
        end
        wait_idle();

        // R6: junk offered while not ready is ignored
        send(8'h5a);
        in_valid = 1'b1;
        in_data  = 8'h05;
        while (exp_q.size() > 3) @(negedge clk);
        in_valid = 1'b0;
        wait_idle();
        repeat (3 * C) begin
            @(negedge clk);
            chk(tx == 1'b1, "R6 line stays idle", int'(tx), 1);
        end
        repeat (2 * C) @(negedge clk);
        chk(sent_q.size() == 0, "R8 all recovered", sent_q.size(), 0);

        // R7: reset in mid-frame
        dec_on = 1'b0;
        send(8'h55);
        repeat (3 * C) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(tx == 1'b1, "R7 tx", int'(tx), 1);
        chk(in_ready == 1'b1, "R7 ready", int'(in_ready), 1);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not end)");
            finish_run();
        end
    end

endmodule